// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block decides which of eleven interrupt sources an 8-bit microcontroller core services next, and when. Each source has two flag inputs that are ORed, an individual enable bit and a priority-level bit (high or low). A single global enable sits above all of the individual enables. Among the sources that are pending and enabled, the high level beats the low level. Within one level, the fixed natural order decides, and source 0 ranks highest.

The controller keeps one in-service flag per level, so a running service routine can be preempted only by a request of strictly higher level. It raises its request only at an instruction boundary reported by the core. An instruction that returns from an interrupt, or that writes the enable or level settings, pushes the request back by one more instruction.

A request carries a source index and a vector address. Both stay fixed until the core acknowledges. The acknowledge marks the granted level as in service.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `glob_en` is 0 no request is raised, whatever the flags and individual enables.
- R2: Source i (i < 6) is enabled by `en_main[i]` and source i (i >= 6) by `en_ext[i-6]`. A disabled source is never granted.
- R3: A source is pending when either `flag_a[i]` or `flag_b[i]` is 1.
- R4: The level of source i comes from `lvl_main[i]` (i < 6) or `lvl_ext[i-6]` (i >= 6), where 1 means high. A pending high-level source wins over every low-level source, whatever their indices.
- R5: Among eligible sources of the same level, the lowest index wins.
- R6: While a low-level routine is in service, only high-level sources can be granted. While a high-level routine is in service, nothing is granted.
- R7: A `cpu_reti` pulse clears the in-service flag of the highest level currently in service.
- R8: `irq_req` rises only in the cycle after a cycle with `cpu_boundary` = 1.
- R9: If `cpu_reti` or `cpu_wr_ctrl` was pulsed during an instruction, no request is raised at that instruction's boundary. The pulse counts for the instruction when it comes at or before that boundary. The following boundary may raise a request.
- R10: While `irq_req` is 1 and not acknowledged, `irq_idx` and `irq_vec` hold. `irq_vec` = 0x0003 + 8 × `irq_idx`, so source 10 gives 0x0053. `irq_req` falls in the cycle after `cpu_ack`.
- R11: An acknowledge of a pending request sets the in-service flag of the granted level.
- R12: Synchronous reset (`rst` = 1) drops `irq_req` and clears both in-service flags and any pending deferral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_a | input | 11 | Primary interrupt flag per source |
| flag_b | input | 11 | Secondary interrupt flag per source, ORed with flag_a |
| glob_en | input | 1 | Global interrupt enable |
| en_main | input | 6 | Individual enables, sources 0 to 5 |
| en_ext | input | 5 | Individual enables, sources 6 to 10 |
| lvl_main | input | 6 | Level bits (1 = high), sources 0 to 5 |
| lvl_ext | input | 5 | Level bits (1 = high), sources 6 to 10 |
| cpu_boundary | input | 1 | Current instruction completes this cycle |
| cpu_reti | input | 1 | Current instruction is a return from interrupt |
| cpu_wr_ctrl | input | 1 | Current instruction writes an enable or level setting |
| cpu_ack | input | 1 | Core accepts the pending request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Index of the granted source |
| irq_vec | output | 16 | Vector address of the granted source |

## Verification
The bench builds the block with its defaults: eleven sources, six on the main enable and level set and five on the extended set. This puts both register halves in play, and the top index 10 tests the vector arithmetic at its largest value (0x0053). The two reserved sources, 8 and 9, are driven directly and take part in arbitration. Directed sequences nest a high routine over a low one and unwind them with returns. A long random phase mixes levels, enables, flag pairs and core strobes against the behavioural model.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NUM_SRC    = 11;
    localparam int BASE_SRCS  = 6;
    localparam int EXT_SRCS   = NUM_SRC - BASE_SRCS;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int NUM_LVL    = 2;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic             valid;
        lvl_e             lvl;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(idx);
    endfunction

endpackage

// File: rtl/irq_src_mask.sv
module irq_src_mask
    import irq_nest_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_BASE = BASE_SRCS,
    localparam int N_EXT = N_SRC - N_BASE
) (
    input  logic [N_SRC-1:0]  flag_a,
    input  logic [N_SRC-1:0]  flag_b,
    input  logic              glob_en,
    input  logic [N_BASE-1:0] en_main,
    input  logic [N_EXT-1:0]  en_ext,
    input  logic [N_BASE-1:0] lvl_main,
    input  logic [N_EXT-1:0]  lvl_ext,
    output logic [N_SRC-1:0]  pend_hi,
    output logic [N_SRC-1:0]  pend_lo
);

    logic [N_SRC-1:0] en_bit;
    logic [N_SRC-1:0] lvl_bit;
    logic [N_SRC-1:0] live;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i < N_BASE) begin : g_main
            assign en_bit[i]  = en_main[i];
            assign lvl_bit[i] = lvl_main[i];
        end else begin : g_ext
            assign en_bit[i]  = en_ext[i-N_BASE];
            assign lvl_bit[i] = lvl_ext[i-N_BASE];
        end
        assign live[i]    = (flag_a[i] | flag_b[i]) & en_bit[i] & glob_en;
        assign pend_hi[i] = live[i] & lvl_bit[i];
        assign pend_lo[i] = live[i] & ~lvl_bit[i];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reti,
    input  logic ack_fire,
    input  lvl_e ack_lvl,
    output logic svc_hi,
    output logic svc_lo
);

    logic hi_d;
    logic lo_d;

    always_comb begin
        hi_d = svc_hi;
        lo_d = svc_lo;
        if (reti) begin
            if (svc_hi) begin
                hi_d = 1'b0;
            end else begin
                lo_d = 1'b0;
            end
        end
        if (ack_fire) begin
            if (ack_lvl == LVL_HIGH) begin
                hi_d = 1'b1;
            end else begin
                lo_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            svc_hi <= hi_d;
            svc_lo <= lo_d;
        end
    end

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
    import irq_nest_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   boundary,
    input  logic   reti,
    input  logic   wr_ctrl,
    input  logic   ack,
    input  grant_t cand,
    output logic   req,
    output grant_t held
);

    logic defer_q;
    logic block;
    logic issue;
    logic take;

    always_comb begin
        block = defer_q | reti | wr_ctrl;
        issue = boundary & ~block & cand.valid & ~req;
        take  = req & ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            defer_q <= 1'b0;
            held    <= '0;
        end else begin
            defer_q <= boundary ? 1'b0 : block;
            if (take) begin
                req <= 1'b0;
            end else if (issue) begin
                req  <= 1'b1;
                held <= cand;
            end
        end
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_BASE = BASE_SRCS,
    localparam int N_EXT = N_SRC - N_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  flag_a,
    input  logic [N_SRC-1:0]  flag_b,
    input  logic              glob_en,
    input  logic [N_BASE-1:0] en_main,
    input  logic [N_EXT-1:0]  en_ext,
    input  logic [N_BASE-1:0] lvl_main,
    input  logic [N_EXT-1:0]  lvl_ext,
    input  logic              cpu_boundary,
    input  logic              cpu_reti,
    input  logic              cpu_wr_ctrl,
    input  logic              cpu_ack,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx,
    output logic [VEC_W-1:0]  irq_vec
);

    logic [N_SRC-1:0] pend_lvl [NUM_LVL];
    logic             pick_v   [NUM_LVL];
    logic [IDX_W-1:0] pick_idx [NUM_LVL];
    logic             svc_hi;
    logic             svc_lo;
    logic             hi_ok;
    logic             lo_ok;
    grant_t           cand;
    grant_t           held;
    logic             ack_fire;

    irq_src_mask #(.N_SRC(N_SRC), .N_BASE(N_BASE)) u_mask (
        .flag_a   (flag_a),
        .flag_b   (flag_b),
        .glob_en  (glob_en),
        .en_main  (en_main),
        .en_ext   (en_ext),
        .lvl_main (lvl_main),
        .lvl_ext  (lvl_ext),
        .pend_hi  (pend_lvl[LVL_HIGH]),
        .pend_lo  (pend_lvl[LVL_LOW])
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
            .req   (pend_lvl[l]),
            .valid (pick_v[l]),
            .idx   (pick_idx[l])
        );
    end

    always_comb begin
        hi_ok = ~svc_hi;
        lo_ok = ~svc_hi & ~svc_lo;
        cand  = '0;
        if (hi_ok && pick_v[LVL_HIGH]) begin
            cand.valid = 1'b1;
            cand.lvl   = LVL_HIGH;
            cand.idx   = pick_idx[LVL_HIGH];
        end else if (lo_ok && pick_v[LVL_LOW]) begin
            cand.valid = 1'b1;
            cand.lvl   = LVL_LOW;
            cand.idx   = pick_idx[LVL_LOW];
        end
    end

    irq_req_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .boundary (cpu_boundary),
        .reti     (cpu_reti),
        .wr_ctrl  (cpu_wr_ctrl),
        .ack      (cpu_ack),
        .cand     (cand),
        .req      (irq_req),
        .held     (held)
    );

    assign ack_fire = irq_req & cpu_ack;

    irq_svc_track u_svc (
        .clk      (clk),
        .rst      (rst),
        .reti     (cpu_reti),
        .ack_fire (ack_fire),
        .ack_lvl  (held.lvl),
        .svc_hi   (svc_hi),
        .svc_lo   (svc_lo)
    );

    assign irq_idx = held.idx;
    assign irq_vec = vec_of(held.idx);

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk
    import irq_nest_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             glob_en,
    input logic             cpu_boundary,
    input logic             cpu_reti,
    input logic             cpu_wr_ctrl,
    input logic             cpu_ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic [VEC_W-1:0] irq_vec,
    input logic             svc_hi,
    input logic             svc_lo
);

    a_r8_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(cpu_boundary));

    a_r9_no_rise_after_defer: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (!$past(cpu_reti) && !$past(cpu_wr_ctrl)));

    a_r1_rise_needs_global: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(glob_en));

    a_r6_high_not_preempted: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> !$past(svc_hi));

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !cpu_ack) |=> (irq_req && $stable(irq_idx) && $stable(irq_vec)));

    a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_req && cpu_ack) |=> !irq_req);

    a_r10_index_in_range: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (32'(irq_idx) < NUM_SRC));

    a_r11_ack_marks_service: assert property (@(posedge clk) disable iff (rst)
        (irq_req && cpu_ack && !cpu_reti) |=> (svc_hi || svc_lo));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_req && !svc_hi && !svc_lo));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .glob_en      (glob_en),
    .cpu_boundary (cpu_boundary),
    .cpu_reti     (cpu_reti),
    .cpu_wr_ctrl  (cpu_wr_ctrl),
    .cpu_ack      (cpu_ack),
    .irq_req      (irq_req),
    .irq_idx      (irq_idx),
    .irq_vec      (irq_vec),
    .svc_hi       (svc_hi),
    .svc_lo       (svc_lo)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;

    localparam int NS = 11;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] flag_a = '0;
    logic [NS-1:0] flag_b = '0;
    logic          glob_en = 1'b0;
    logic [NS-1:0] en  = '0;
    logic [NS-1:0] lvl = '0;
    logic          cpu_boundary = 1'b0;
    logic          cpu_reti = 1'b0;
    logic          cpu_wr_ctrl = 1'b0;
    logic          cpu_ack = 1'b0;
    logic          irq_req;
    logic [3:0]    irq_idx;
    logic [15:0]   irq_vec;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R12";

    // reference model state
    bit m_req, m_defer, m_shi, m_slo, m_lvl;
    int m_idx;

    always #5 clk = ~clk;

    irq_nest_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .flag_a       (flag_a),
        .flag_b       (flag_b),
        .glob_en      (glob_en),
        .en_main      (en[NB-1:0]),
        .en_ext       (en[NS-1:NB]),
        .lvl_main     (lvl[NB-1:0]),
        .lvl_ext      (lvl[NS-1:NB]),
        .cpu_boundary (cpu_boundary),
        .cpu_reti     (cpu_reti),
        .cpu_wr_ctrl  (cpu_wr_ctrl),
        .cpu_ack      (cpu_ack),
        .irq_req      (irq_req),
        .irq_idx      (irq_idx),
        .irq_vec      (irq_vec)
    );

    always @(posedge clk) begin
        bit found, fl, blk, issue, ackd;
        int c_idx;
        found = 0; fl = 0; c_idx = 0;
        if (rst) begin
            m_req = 0; m_defer = 0; m_shi = 0; m_slo = 0; m_lvl = 0; m_idx = 0;
        end else begin
            for (int lv = 1; lv >= 0; lv--) begin
                bit allowed;
                allowed = (lv == 1) ? !m_shi : (!m_shi && !m_slo);
                for (int i = 0; i < NS; i++) begin
                    if (!found && allowed && glob_en && en[i] &&
                        (flag_a[i] || flag_b[i]) && (int'(lvl[i]) == lv)) begin
                        found = 1; c_idx = i; fl = (lv == 1);
                    end
                end
            end
            blk   = m_defer || cpu_reti || cpu_wr_ctrl;
            issue = cpu_boundary && !blk && found && !m_req;
            ackd  = m_req && cpu_ack;
            if (cpu_reti) begin
                if (m_shi) m_shi = 0; else m_slo = 0;
            end
            if (ackd) begin
                if (m_lvl) m_shi = 1; else m_slo = 1;
            end
            m_defer = cpu_boundary ? 0 : blk;
            if (ackd) m_req = 0;
            else if (issue) begin
                m_req = 1; m_idx = c_idx; m_lvl = fl;
            end
        end
    end

    task automatic compare();
        n_cmp++;
        if (irq_req !== m_req) begin
            n_bad++;
            $display("FAIL %s req actual=%0b expected=%0b t=%0t", tag, irq_req, m_req, $time);
        end else if (m_req) begin
            if (int'(irq_idx) != m_idx || int'(irq_vec) != 3 + 8 * m_idx) begin
                n_bad++;
                $display("FAIL %s idx/vec actual=%0d/%h expected=%0d/%h", tag,
                         irq_idx, irq_vec, m_idx, 3 + 8 * m_idx);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare();
    endtask

    task automatic expect_out(input bit req, input int idx, input string t);
        n_cmp++;
        if (irq_req !== req || (req && (int'(irq_idx) != idx || int'(irq_vec) != 3 + 8 * idx))) begin
            n_bad++;
            $display("FAIL %s actual req=%0b idx=%0d vec=%h expected req=%0b idx=%0d vec=%h",
                     t, irq_req, irq_idx, irq_vec, req, idx, 3 + 8 * idx);
        end
    endtask

    task automatic bnd(input bit reti, input bit wr);
        cpu_boundary = 1; cpu_reti = reti; cpu_wr_ctrl = wr;
        tick();
        cpu_boundary = 0; cpu_reti = 0; cpu_wr_ctrl = 0;
    endtask

    task automatic ack();
        cpu_ack = 1;
        tick();
        cpu_ack = 0;
    endtask

    task automatic do_reset();
        rst = 1; flag_a = '0; flag_b = '0;
        tick(); tick();
        rst = 0;
        tick();
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        expect_out(0, 0, "R12 reset");
        rst = 0; glob_en = 1; en = '1; lvl = '0;
        tick();

        // R12: deferral pending before reset is cleared
        tag = "R12";
        cpu_wr_ctrl = 1; tick(); cpu_wr_ctrl = 0;
        rst = 1; tick(); rst = 0; tick();
        flag_a = 11'h001;
        bnd(0, 0);
        expect_out(1, 0, "R12 defer cleared");
        ack(); flag_a = '0; bnd(1, 0);
        do_reset();

        // R1: global enable off
        tag = "R1";
        glob_en = 0; flag_a = '1;
        bnd(0, 0); bnd(0, 0);
        expect_out(0, 0, "R1 global off");
        glob_en = 1; flag_a = '0;
        do_reset();

        // R2: only source 7 (extended bit 1) enabled
        tag = "R2";
        en = 11'b000_1000_0000; flag_a = '1;
        bnd(0, 0);
        expect_out(1, 7, "R2 ext enable");
        ack(); flag_a = '0; en = '1;
        do_reset();

        // R3: secondary flag alone
        tag = "R3";
        flag_b = 11'h010;
        bnd(0, 0);
        expect_out(1, 4, "R3 flag_b");
        ack(); flag_b = '0;
        do_reset();

        // R4: high source 8 beats low source 0
        tag = "R4";
        lvl = 11'h100; flag_a = 11'h101;
        bnd(0, 0);
        expect_out(1, 8, "R4 level first");
        ack(); flag_a = '0; lvl = '0;
        do_reset();

        // R5: same level tie, reserved source 9 against source 2
        tag = "R5";
        flag_a = 11'h204;
        bnd(0, 0);
        expect_out(1, 2, "R5 low tie");
        ack(); flag_a = '0;
        do_reset();
        lvl = 11'h204; flag_a = 11'h200;
        bnd(0, 0);
        expect_out(1, 9, "R5 reserved source");
        ack(); flag_a = '0; lvl = '0;
        do_reset();

        // R6 / R7 / R11 nesting
        tag = "R6";
        flag_a = 11'h008;
        bnd(0, 0);
        expect_out(1, 3, "R11 low grant");
        ack();
        expect_out(0, 0, "R10 drop after ack");
        flag_a = 11'h00A;
        bnd(0, 0);
        expect_out(0, 0, "R6 low blocked by low");
        flag_a = 11'h40A; lvl = 11'h400;
        bnd(0, 0);
        expect_out(1, 10, "R6 high nests, R10 vec 0x53");
        ack();
        flag_a = 11'h40B; lvl = 11'h401;
        bnd(0, 0);
        expect_out(0, 0, "R6 high never preempted");
        tag = "R7";
        bnd(1, 0);
        expect_out(0, 0, "R9 reti boundary blocked");
        bnd(0, 0);
        expect_out(1, 0, "R7 high cleared, low still held");
        ack(); flag_a = '0; lvl = '0;
        bnd(1, 0); bnd(1, 0); bnd(1, 0);
        do_reset();

        // R8 and R10 hold
        tag = "R8";
        flag_a = 11'h020;
        for (int k = 0; k < 4; k++) tick();
        expect_out(0, 0, "R8 no boundary");
        bnd(0, 0);
        expect_out(1, 5, "R8 boundary");
        tag = "R10";
        flag_a = '0; en = '0;
        tick(); tick(); tick();
        expect_out(1, 5, "R10 held");
        ack();
        expect_out(0, 0, "R10 drop");
        en = '1;
        do_reset();

        // R9 deferral
        tag = "R9";
        flag_a = 11'h004;
        bnd(0, 1);
        expect_out(0, 0, "R9 write boundary");
        bnd(0, 0);
        expect_out(1, 2, "R9 next boundary");
        ack(); do_reset();
        flag_a = 11'h004;
        cpu_wr_ctrl = 1; tick(); cpu_wr_ctrl = 0; tick();
        bnd(0, 0);
        expect_out(0, 0, "R9 mid-instruction write");
        bnd(0, 0);
        expect_out(1, 2, "R9 after extra instruction");
        ack(); flag_a = '0;
        do_reset();

        // mixed random traffic against the model
        tag = "RND";
        for (int k = 0; k < 4000; k++) begin
            flag_a  = 11'($urandom) & 11'($urandom);
            flag_b  = 11'($urandom) & 11'($urandom) & 11'($urandom);
            if (k % 64 == 0) begin
                en  = 11'($urandom) | 11'($urandom);
                lvl = 11'($urandom) & 11'($urandom);
                glob_en = ($urandom % 8) != 0;
            end
            cpu_boundary = ($urandom % 3) == 0;
            cpu_ack      = irq_req && (($urandom % 3) == 0);
            cpu_reti     = !cpu_ack && (($urandom % 9) == 0);
            cpu_wr_ctrl  = ($urandom % 11) == 0;
            tick();
        end
        cpu_boundary = 0; cpu_ack = 0; cpu_reti = 0; cpu_wr_ctrl = 0;
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule